// File: doc/BRIEF.md
# Glitch-Free Base Clock Selector

This block chooses whether the crystal reference clock or the PLL's VCO clock drives the base clock of the chip. A select request comes from a small control register. It does not reach the output mux directly. A handshake turns off the old clock on its falling edge and then turns on the new clock on its falling edge, with each step synchronized in the domain it affects. While the switch is in progress, the mux output stays low and the divided clocks keep their levels. The muxed clock is divided by two to give the base clock, and divided by two again to give the bus clock. The bus clock therefore runs at a quarter of the selected source.

The control register is written on the crystal clock. It holds the VCO select bit, the PLL enable and the two multiplier fields. It applies a set of write rules so that the PLL enable and the VCO select can never reach an illegal combination. The PLL enable output goes to the analog PLL. The multiplier fields are passed on with zero values already interpreted. A status output reports which clock is actually driving the base clock.

Top module: `base_clock_select`

## Requirements
- R1: After reset the VCO select and the PLL enable read 0, the L field reads 0, `src_vco` is 0, and the crystal clock drives the output, so `bus_clk` has a period of four crystal periods.
- R2: The two clock enables are never on at the same time. No interval between successive `base_clk` edges is shorter than one period of the faster source clock, including intervals that span a switchover.
- R3: `base_clk` toggles on every rising edge of the selected clock, and `bus_clk` toggles on every rising edge of `base_clk`. The `bus_clk` period is four periods of the selected source.
- R4: `src_vco` is 1 when the VCO clock drives the mux and 0 when the crystal clock drives it. It changes only after the handshake has finished, so directly after a select write it still shows the old source.
- R5: A write that sets the VCO select while the PLL enable is 0 leaves the select at 0. A write that clears the PLL enable while the VCO select is 1 leaves the enable at 1.
- R6: If one write changes both the PLL enable and the VCO select, both bits keep their previous values. The multiplier fields of that write are still stored.
- R7: If a write leaves the L field at 0, the PLL enable and the VCO select are both cleared, whatever else the write asks for. The crystal clock then drives the output.
- R8: An N field of 0 reads back on `ctl_mul_n` as 1. Any other value reads back unchanged.
- R9: The register is updated only on a rising crystal clock edge with `wr_en` at 1. With `wr_en` at 0 the register holds, whatever the write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal reference clock, also the register clock |
| clk_vco | input | 1 | VCO clock from the PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel_vco | input | 1 | Requested VCO select |
| wr_pll_on | input | 1 | Requested PLL enable |
| wr_mul_l | input | L_W | Requested L multiplier |
| wr_mul_n | input | N_W | Requested N multiplier |
| ctl_sel_vco | output | 1 | Stored VCO select |
| ctl_pll_on | output | 1 | PLL enable to the analog PLL |
| ctl_mul_l | output | L_W | Stored L multiplier |
| ctl_mul_n | output | N_W | N multiplier, with 0 read as 1 |
| base_clk | output | 1 | Selected clock divided by two |
| bus_clk | output | 1 | Selected clock divided by four |
| src_vco | output | 1 | 1 when the VCO clock drives the output |

## Verification
The bench builds the block with its default field widths: 6 bits for L and 8 bits for N. At these widths the zero values of both fields can be written next to ordinary non-zero values, so the L-zero override and the N-zero reinterpretation are both exercised. The crystal runs at 8 ns and the VCO at 6 ns. Because the VCO is the faster clock, each switch in either direction produces a measurably different bus period. An edge-spacing monitor on `base_clk` would catch any runt pulse that appears while the enables hand over.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
    // two-stage synchronizer state
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    localparam int unsigned DEF_L_W = 6;
    localparam int unsigned DEF_N_W = 8;
endpackage

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl #(
    parameter int unsigned L_W = 6,
    parameter int unsigned N_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_sel,
    input  logic           wr_pll,
    input  logic [L_W-1:0] wr_l,
    input  logic [N_W-1:0] wr_n,
    output logic           sel_o,
    output logic           pll_o,
    output logic [L_W-1:0] l_o,
    output logic [N_W-1:0] n_o
);
    localparam logic [N_W-1:0] N_ONE = N_W'(1);

    typedef struct packed {
        logic           sel;
        logic           pll;
        logic [L_W-1:0] l;
        logic [N_W-1:0] n;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        logic pll_chg, sel_chg;
        r_d     = r_q;
        pll_chg = wr_pll != r_q.pll;
        sel_chg = wr_sel != r_q.sel;
        if (wr_en) begin
            r_d.l = wr_l;
            r_d.n = wr_n;
            if (!(pll_chg && sel_chg)) begin
                // clearing the enable is refused while the VCO is selected
                if (pll_chg && !(r_q.pll && r_q.sel))
                    r_d.pll = wr_pll;
                if (sel_chg) begin
                    if (!wr_sel)
                        r_d.sel = 1'b0;
                    else if (r_q.pll && (wr_l != '0))
                        r_d.sel = 1'b1;
                end
            end
            if (wr_l == '0) begin
                r_d.pll = 1'b0;
                r_d.sel = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sel_o = r_q.sel;
    assign pll_o = r_q.pll;
    assign l_o   = r_q.l;
    assign n_o   = (r_q.n == '0) ? N_ONE : r_q.n;
endmodule

// File: rtl/clksel_handshake.sv
`timescale 1ns/1ps
module clksel_handshake
    import clksel_pkg::*;
(
    input  logic clk_xtal,
    input  logic clk_vco,
    input  logic rst_n,
    input  logic want_vco,
    output logic en_x,
    output logic en_v
);
    sync_t sx_d, sx_q, sv_d, sv_q;
    logic  enx_d, enx_q, env_d, env_q;

    // crystal side: learn that the VCO enable is off, then enable on falling edge
    always_comb begin
        sx_d.s1 = ~env_q;
        sx_d.s2 = sx_q.s1;
        enx_d   = ~want_vco & sx_q.s2;
    end

    // VCO side: learn that the crystal enable is off, then enable on falling edge
    always_comb begin
        sv_d.s1 = want_vco & ~enx_q;
        sv_d.s2 = sv_q.s1;
        env_d   = sv_q.s2;
    end

    always_ff @(posedge clk_xtal or negedge rst_n) begin
        if (!rst_n) sx_q <= '1;
        else        sx_q <= sx_d;
    end

    always_ff @(negedge clk_xtal or negedge rst_n) begin
        if (!rst_n) enx_q <= 1'b1;
        else        enx_q <= enx_d;
    end

    always_ff @(posedge clk_vco or negedge rst_n) begin
        if (!rst_n) sv_q <= '0;
        else        sv_q <= sv_d;
    end

    always_ff @(negedge clk_vco or negedge rst_n) begin
        if (!rst_n) env_q <= 1'b0;
        else        env_q <= env_d;
    end

    assign en_x = enx_q;
    assign en_v = env_q;
endmodule

// File: rtl/clksel_divider.sv
`timescale 1ns/1ps
module clksel_divider (
    input  logic clk_xtal,
    input  logic clk_vco,
    input  logic rst_n,
    input  logic en_x,
    input  logic en_v,
    output logic base_clk,
    output logic bus_clk,
    output logic src_vco
);
    typedef struct packed {
        logic base;
        logic src;
    } div_t;

    logic mux_clk;
    div_t d_d, d_q;
    logic bus_d, bus_q;

    // enables only change while their own clock is low
    assign mux_clk = (clk_xtal & en_x) | (clk_vco & en_v);

    always_comb begin
        d_d.base = ~d_q.base;
        d_d.src  = en_v;
        bus_d    = ~bus_q;
    end

    always_ff @(posedge mux_clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    always_ff @(posedge d_q.base or negedge rst_n) begin
        if (!rst_n) bus_q <= 1'b0;
        else        bus_q <= bus_d;
    end

    assign base_clk = d_q.base;
    assign bus_clk  = bus_q;
    assign src_vco  = d_q.src;
endmodule

// File: rtl/base_clock_select.sv
`timescale 1ns/1ps
module base_clock_select #(
    parameter int unsigned L_W = clksel_pkg::DEF_L_W,
    parameter int unsigned N_W = clksel_pkg::DEF_N_W
) (
    input  logic           clk_xtal,
    input  logic           clk_vco,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_sel_vco,
    input  logic           wr_pll_on,
    input  logic [L_W-1:0] wr_mul_l,
    input  logic [N_W-1:0] wr_mul_n,
    output logic           ctl_sel_vco,
    output logic           ctl_pll_on,
    output logic [L_W-1:0] ctl_mul_l,
    output logic [N_W-1:0] ctl_mul_n,
    output logic           base_clk,
    output logic           bus_clk,
    output logic           src_vco
);
    logic en_x, en_v;

    clksel_ctrl #(.L_W(L_W), .N_W(N_W)) i_ctrl (
        .clk    (clk_xtal),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel_vco),
        .wr_pll (wr_pll_on),
        .wr_l   (wr_mul_l),
        .wr_n   (wr_mul_n),
        .sel_o  (ctl_sel_vco),
        .pll_o  (ctl_pll_on),
        .l_o    (ctl_mul_l),
        .n_o    (ctl_mul_n)
    );

    clksel_handshake i_hs (
        .clk_xtal (clk_xtal),
        .clk_vco  (clk_vco),
        .rst_n    (rst_n),
        .want_vco (ctl_sel_vco),
        .en_x     (en_x),
        .en_v     (en_v)
    );

    clksel_divider i_div (
        .clk_xtal (clk_xtal),
        .clk_vco  (clk_vco),
        .rst_n    (rst_n),
        .en_x     (en_x),
        .en_v     (en_v),
        .base_clk (base_clk),
        .bus_clk  (bus_clk),
        .src_vco  (src_vco)
    );
endmodule

// File: rtl/clksel_checker.sv
`timescale 1ns/1ps
module clksel_checker #(
    parameter int unsigned L_W = 6
) (
    input logic           clk_xtal,
    input logic           clk_vco,
    input logic           rst_n,
    input logic           wr_en,
    input logic           wr_sel_vco,
    input logic           wr_pll_on,
    input logic [L_W-1:0] wr_mul_l,
    input logic           ctl_sel_vco,
    input logic           ctl_pll_on,
    input logic [L_W-1:0] ctl_mul_l,
    input logic           en_x,
    input logic           en_v
);
    assert_mutex_x_R2: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        !(en_x && en_v));

    assert_mutex_v_R2: assert property (@(posedge clk_vco) disable iff (!rst_n)
        !(en_x && en_v));

    assert_sel_needs_pll_R5: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        ctl_sel_vco |-> ctl_pll_on);

    assert_combined_refused_R6: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        (wr_en && (wr_pll_on != ctl_pll_on) && (wr_sel_vco != ctl_sel_vco) && (wr_mul_l != '0))
        |=> ($stable(ctl_pll_on) && $stable(ctl_sel_vco)));

    assert_lzero_off_R7: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        (ctl_mul_l == '0) |-> (!ctl_pll_on && !ctl_sel_vco));

    assert_hold_idle_R9: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        !wr_en |=> ($stable(ctl_mul_l) && $stable(ctl_sel_vco) && $stable(ctl_pll_on)));
endmodule

bind base_clock_select clksel_checker #(.L_W(L_W)) i_chk (
    .clk_xtal    (clk_xtal),
    .clk_vco     (clk_vco),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel_vco  (wr_sel_vco),
    .wr_pll_on   (wr_pll_on),
    .wr_mul_l    (wr_mul_l),
    .ctl_sel_vco (ctl_sel_vco),
    .ctl_pll_on  (ctl_pll_on),
    .ctl_mul_l   (ctl_mul_l),
    .en_x        (en_x),
    .en_v        (en_v)
);

// File: tb/test_base_clock_select.sv
`timescale 1ns/1ps
module test_base_clock_select;
    localparam int unsigned L_W = 6;
    localparam int unsigned N_W = 8;

    logic           clk_xtal = 1'b0;
    logic           clk_vco  = 1'b0;
    logic           rst_n    = 1'b0;
    logic           wr_en    = 1'b0;
    logic           wr_sel_vco = 1'b0;
    logic           wr_pll_on  = 1'b0;
    logic [L_W-1:0] wr_mul_l   = '0;
    logic [N_W-1:0] wr_mul_n   = '0;
    logic           ctl_sel_vco, ctl_pll_on, base_clk, bus_clk, src_vco;
    logic [L_W-1:0] ctl_mul_l;
    logic [N_W-1:0] ctl_mul_n;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  n_runt   = 0;
    real last_edge = 0.0;
    bit  done = 1'b0;

    always #4 clk_xtal = ~clk_xtal;   // 125 MHz
    always #3 clk_vco  = ~clk_vco;

    base_clock_select #(.L_W(L_W), .N_W(N_W)) i_base_clock_select (
        .clk_xtal, .clk_vco, .rst_n, .wr_en, .wr_sel_vco, .wr_pll_on,
        .wr_mul_l, .wr_mul_n, .ctl_sel_vco, .ctl_pll_on, .ctl_mul_l,
        .ctl_mul_n, .base_clk, .bus_clk, .src_vco
    );

    // R2 monitor: spacing of base_clk edges
    always @(base_clk) begin
        if (rst_n) begin
            if (last_edge > 0.0 && ($realtime - last_edge) < 5.5) n_runt++;
            last_edge = $realtime;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic pll,
                            input int l, input int n);
        @(negedge clk_xtal);
        wr_sel_vco = sel; wr_pll_on = pll;
        wr_mul_l = L_W'(l); wr_mul_n = N_W'(n); wr_en = 1'b1;
        @(posedge clk_xtal);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_period(input string req, input int exp_ns);
        real t0;
        @(posedge bus_clk); t0 = $realtime;
        @(posedge bus_clk);
        chk(req, int'($realtime - t0), exp_ns);
    endtask

    task automatic settle();
        repeat (40) @(posedge clk_xtal);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 sel", ctl_sel_vco, 0);
        chk("R1 pll", ctl_pll_on, 0);
        chk("R1 L", ctl_mul_l, 0);
        chk("R1 src", src_vco, 0);
        bus_period("R1 bus period", 32);
    endtask

    task automatic t_idle_inputs();
        @(negedge clk_xtal);
        wr_sel_vco = 1'b1; wr_pll_on = 1'b1; wr_mul_l = 6'd3; wr_mul_n = 8'd5;
        repeat (3) @(posedge clk_xtal);
        #1;
        chk("R9 sel held", ctl_sel_vco, 0);
        chk("R9 pll held", ctl_pll_on, 0);
        chk("R9 L held", ctl_mul_l, 0);
    endtask

    task automatic t_select_without_pll();
        do_write(1'b1, 1'b0, 4, 0);
        chk("R5 sel refused", ctl_sel_vco, 0);
        chk("R9 L written", ctl_mul_l, 4);
        chk("R8 N zero", ctl_mul_n, 1);
        do_write(1'b0, 1'b1, 4, 7);
        chk("R5 pll on", ctl_pll_on, 1);
        chk("R8 N plain", ctl_mul_n, 7);
    endtask

    task automatic t_combined();
        do_write(1'b1, 1'b0, 9, 0);
        chk("R6 pll kept", ctl_pll_on, 1);
        chk("R6 sel kept", ctl_sel_vco, 0);
        chk("R6 L stored", ctl_mul_l, 9);
        chk("R6 N stored", ctl_mul_n, 1);
    endtask

    task automatic t_to_vco();
        do_write(1'b1, 1'b1, 9, 2);
        chk("R5 sel set", ctl_sel_vco, 1);
        chk("R4 src early", src_vco, 0);
        settle();
        chk("R4 src vco", src_vco, 1);
        bus_period("R3 bus vco", 24);
    endtask

    task automatic t_pll_off_blocked();
        do_write(1'b1, 1'b0, 9, 2);
        chk("R5 pll kept", ctl_pll_on, 1);
        chk("R5 sel stays", ctl_sel_vco, 1);
    endtask

    task automatic t_to_xtal();
        do_write(1'b0, 1'b1, 9, 2);
        chk("R4 sel cleared", ctl_sel_vco, 0);
        chk("R4 src late", src_vco, 1);
        settle();
        chk("R4 src xtal", src_vco, 0);
        bus_period("R3 bus xtal", 32);
    endtask

    task automatic t_lzero();
        do_write(1'b1, 1'b1, 9, 2);
        settle();
        chk("R7 pre src", src_vco, 1);
        do_write(1'b1, 1'b1, 0, 2);
        chk("R7 pll off", ctl_pll_on, 0);
        chk("R7 sel off", ctl_sel_vco, 0);
        settle();
        chk("R7 src xtal", src_vco, 0);
        bus_period("R7 bus xtal", 32);
        do_write(1'b0, 1'b1, 0, 2);
        chk("R7 pll blocked", ctl_pll_on, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk_xtal);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk_xtal);
        #1;
        t_reset();
        t_idle_inputs();
        t_select_without_pll();
        t_combined();
        t_to_vco();
        t_pll_off_blocked();
        t_to_xtal();
        t_lzero();
        chk("R2 runt edges", n_runt, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk_xtal);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule